// File: doc/BRIEF.md
# Scanline Position Interrupt Generator

This block raises three raster-position interrupt pulses for a video timing unit. It watches the live line counter, the odd/even field flag and the pixel-within-line counter that the raster timing block produces. Two vertical compare channels (scanline1 and scanline2) fire at the start of a chosen line. A horizontal compare channel (hpos) fires at a chosen pixel of a chosen line. The hpos channel can fire once per frame, or it can keep firing every N lines with a target that wraps.

Compare lines are given in field units. A programmed line n stands for raster line 2n in the even field and raster line 2n+1 in the odd field. Software loads the two compare words through plain write strobes with a shared data bus. All matching is done against the live counters, so no time-based scheduling is involved.

Top module: `scan_irq_top`

## Requirements
- R1: The vertical compare word is written when `vcmp_we_i` is high. Bits 25:16 set the scanline1 target, bits 9:0 set the scanline2 target, and every other bit is ignored.
- R2: A vertical target n matches when `line_i` equals 2n and `field_odd_i`=0, or when `line_i` equals 2n+1 and `field_odd_i`=1, and `pixel_i`=0. The pulse appears on the output one clock after the input cycle that matches.
- R3: A channel whose mapped line (2n + field) is greater than or equal to `total_lines_i` never fires.
- R4: The horizontal compare word uses bits 9:0 for the line, bits 13:12 for the mode and bits 25:16 for the pixel position. In mode 0, hpos fires on the mapped line when `pixel_i` equals the position.
- R5: Mode 3 behaves exactly like mode 0.
- R6: Mode 1 repeats every N lines, where N is the line field. On a write, the first target is `line_i`/2 + N. After each fire, N is added to the target. Every new target is wrapped by repeatedly taking away half of `total_lines_i` until it is no greater than that half.
- R7: Mode 2 behaves like mode 1 with N forced to 1.
- R8: A pixel position greater than or equal to `line_len_i` is clamped to `line_len_i`-1.
- R9: Each pulse is one clock wide. A match held over several cycles yields a single pulse.
- R10: After reset all outputs are low, both vertical targets are 0, and hpos is in mode 0 with line 0 and pixel 0. A write takes effect from the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 10 | Current raster line |
| field_odd_i | input | 1 | Field flag, 1 = odd field |
| pixel_i | input | 10 | Pixel position within the line |
| total_lines_i | input | 11 | Lines per frame |
| line_len_i | input | 11 | Pixels per line |
| vcmp_we_i | input | 1 | Write strobe for the vertical compare word |
| hcmp_we_i | input | 1 | Write strobe for the horizontal compare word |
| wdata_i | input | 32 | Write data |
| scanline1_o | output | 1 | scanline1 interrupt pulse |
| scanline2_o | output | 1 | scanline2 interrupt pulse |
| hpos_o | output | 1 | Horizontal position interrupt pulse |

## Verification
A vector table sweeps raster positions against fixed targets. Even and odd field cases on the mapped lines separate the 2n and 2n+1 mapping. Cases with the wrong field, the wrong pixel or a line one step off show that the line, field and pixel terms all take part in the match. Directed sequences then cover the repeat modes: a repeat that passes the half-frame point shows the wrap, a step larger than half a frame shows that the wrap repeats, and a line that must not fire shows the target really moved. Further cases cover out-of-range targets, reserved mode 3, a clamped position, garbage in the unused word bits, and a match held over several cycles.

// File: rtl/scan_irq_pkg.sv
package scan_irq_pkg;
  localparam int unsigned VT1_LSB  = 16;
  localparam int unsigned VT2_LSB  = 0;
  localparam int unsigned HLN_LSB  = 0;
  localparam int unsigned HMODE_LSB = 12;
  localparam int unsigned HPOS_LSB = 16;

  typedef enum logic {HM_FRAME = 1'b0, HM_REPEAT = 1'b1} hmode_e;

  // Bring t into 1..half by repeated subtraction of half (closed form).
  function automatic logic [15:0] wrap_line(input logic [15:0] t, input logic [15:0] half);
    if (half == '0 || t <= half) return t;
    return ((t - 16'd1) % half) + 16'd1;
  endfunction
endpackage

// File: rtl/scan_match.sv
module scan_match #(
  parameter int unsigned LINE_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LINE_W-1:0] tgt_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic              field_odd_i,
  input  logic [LINE_W:0]   total_lines_i,
  input  logic              at_pixel_i,
  output logic              rise_o,
  output logic              pulse_o
);
  logic [LINE_W:0] mapped;
  logic            hit, hit_q;

  assign mapped = {tgt_i, field_odd_i};
  assign hit    = at_pixel_i && (mapped < total_lines_i) && (mapped == {1'b0, line_i});
  assign rise_o = hit && !hit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q   <= 1'b0;
      pulse_o <= 1'b0;
    end else begin
      hit_q   <= hit;
      pulse_o <= rise_o;
    end
  end
endmodule

// File: rtl/scan_hpos_ctl.sv
module scan_hpos_ctl
  import scan_irq_pkg::*;
#(
  parameter int unsigned LINE_W = 10,
  parameter int unsigned PIX_W  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [31:0]       wdata_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [LINE_W:0]   total_lines_i,
  input  logic [PIX_W:0]    line_len_i,
  input  logic              fire_i,
  output logic [LINE_W-1:0] tgt_o,
  output logic [PIX_W:0]    pos_o
);
  logic [LINE_W-1:0] tgt_q, step_q;
  logic [PIX_W-1:0]  pos_q;
  hmode_e            mode_q;

  logic [LINE_W-1:0] w_line;
  logic [1:0]        w_mode;
  logic [PIX_W-1:0]  w_pos;
  logic [LINE_W-1:0] w_step;
  logic [15:0]       half, start_t, next_t;

  assign w_line = wdata_i[HLN_LSB +: LINE_W];
  assign w_mode = wdata_i[HMODE_LSB +: 2];
  assign w_pos  = wdata_i[HPOS_LSB +: PIX_W];
  assign w_step = (w_mode == 2'd2) ? LINE_W'(1) : w_line;

  assign half    = 16'(total_lines_i >> 1);
  assign start_t = wrap_line(16'(line_i >> 1) + 16'(w_step), half);
  assign next_t  = wrap_line(16'(tgt_q) + 16'(step_q), half);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_q  <= '0;
      step_q <= '0;
      pos_q  <= '0;
      mode_q <= HM_FRAME;
    end else if (we_i) begin
      pos_q <= w_pos;
      if (w_mode == 2'd1 || w_mode == 2'd2) begin
        mode_q <= HM_REPEAT;
        step_q <= w_step;
        tgt_q  <= LINE_W'(start_t);
      end else begin
        mode_q <= HM_FRAME;
        step_q <= '0;
        tgt_q  <= w_line;
      end
    end else if (fire_i && mode_q == HM_REPEAT) begin
      tgt_q <= LINE_W'(next_t);
    end
  end

  assign tgt_o = tgt_q;
  assign pos_o = ({1'b0, pos_q} >= line_len_i) ? line_len_i - 1'b1 : {1'b0, pos_q};
endmodule

// File: rtl/scan_irq_top.sv
module scan_irq_top
  import scan_irq_pkg::*;
#(
  parameter int unsigned LINE_W = 10,
  parameter int unsigned PIX_W  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LINE_W-1:0] line_i,
  input  logic              field_odd_i,
  input  logic [PIX_W-1:0]  pixel_i,
  input  logic [LINE_W:0]   total_lines_i,
  input  logic [PIX_W:0]    line_len_i,
  input  logic              vcmp_we_i,
  input  logic              hcmp_we_i,
  input  logic [31:0]       wdata_i,
  output logic              scanline1_o,
  output logic              scanline2_o,
  output logic              hpos_o
);
  localparam int unsigned NUM_V = 2;
  localparam int unsigned V_LSB [NUM_V] = '{VT1_LSB, VT2_LSB};

  logic [LINE_W-1:0] vtgt_q [NUM_V];
  logic [NUM_V-1:0]  v_pulse;
  logic              pix_zero;

  assign pix_zero = (pixel_i == '0);

  for (genvar g = 0; g < NUM_V; g++) begin : g_vch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        vtgt_q[g] <= '0;
      else if (vcmp_we_i) vtgt_q[g] <= wdata_i[V_LSB[g] +: LINE_W];
    end

    logic unused_rise;
    scan_match #(.LINE_W(LINE_W)) u_vm (
      .clk_i, .rst_ni,
      .tgt_i(vtgt_q[g]), .line_i, .field_odd_i, .total_lines_i,
      .at_pixel_i(pix_zero), .rise_o(unused_rise), .pulse_o(v_pulse[g])
    );
  end

  assign scanline1_o = v_pulse[0];
  assign scanline2_o = v_pulse[1];

  logic [LINE_W-1:0] h_tgt;
  logic [PIX_W:0]    h_pos;
  logic              h_rise;

  scan_hpos_ctl #(.LINE_W(LINE_W), .PIX_W(PIX_W)) u_hctl (
    .clk_i, .rst_ni, .we_i(hcmp_we_i), .wdata_i, .line_i, .total_lines_i,
    .line_len_i, .fire_i(h_rise), .tgt_o(h_tgt), .pos_o(h_pos)
  );

  scan_match #(.LINE_W(LINE_W)) u_hm (
    .clk_i, .rst_ni,
    .tgt_i(h_tgt), .line_i, .field_odd_i, .total_lines_i,
    .at_pixel_i({1'b0, pixel_i} == h_pos), .rise_o(h_rise), .pulse_o(hpos_o)
  );
endmodule

// File: rtl/scan_irq_chk.sv
module scan_irq_chk #(
  parameter int unsigned LINE_W = 10,
  parameter int unsigned PIX_W  = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [LINE_W-1:0] line_i,
  input logic              field_odd_i,
  input logic [PIX_W-1:0]  pixel_i,
  input logic [LINE_W:0]   total_lines_i,
  input logic [PIX_W:0]    line_len_i,
  input logic              scanline1_o,
  input logic              scanline2_o,
  input logic              hpos_o
);
  p_s1_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scanline1_o |=> !scanline1_o);
  p_s2_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scanline2_o |=> !scanline2_o);
  p_h_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hpos_o |=> !hpos_o);
  p_s1_parity_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scanline1_o |-> ($past(line_i[0]) == $past(field_odd_i)) && ($past(pixel_i) == '0));
  p_s2_parity_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scanline2_o |-> ($past(line_i[0]) == $past(field_odd_i)) && ($past(pixel_i) == '0));
  p_s1_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scanline1_o |-> ({1'b0, $past(line_i)} < $past(total_lines_i)));
  p_h_parity_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hpos_o |-> ($past(line_i[0]) == $past(field_odd_i)));
  p_h_clamp_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hpos_o |-> ({1'b0, $past(pixel_i)} < $past(line_len_i)));
endmodule

bind scan_irq_top scan_irq_chk #(.LINE_W(LINE_W), .PIX_W(PIX_W)) u_chk (
  .clk_i, .rst_ni, .line_i, .field_odd_i, .pixel_i, .total_lines_i, .line_len_i,
  .scanline1_o, .scanline2_o, .hpos_o
);

// File: tb/scan_irq_top_tb.sv
module scan_irq_top_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [9:0]  line_i = 10'd19;
  logic        field_odd_i = 1'b0;
  logic [9:0]  pixel_i = 10'd50;
  logic [10:0] total_lines_i = 11'd20;
  logic [10:0] line_len_i = 11'd100;
  logic        vcmp_we_i = 1'b0, hcmp_we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic        scanline1_o, scanline2_o, hpos_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  scan_irq_top u_dut (.*);

  // table: line, odd, pixel, expected {s1,s2,h}; s1=3, s2=7, h mode0 line5 pos20
  localparam int NV = 10;
  localparam int VL [NV] = '{6, 7, 6, 14, 15, 6, 10, 11, 10, 11};
  localparam int VO [NV] = '{0, 1, 1, 0, 1, 0, 0, 1, 0, 0};
  localparam int VP [NV] = '{0, 0, 0, 0, 0, 5, 20, 20, 21, 20};
  localparam int VE [NV] = '{4, 4, 0, 2, 2, 0, 1, 1, 0, 0};

  task automatic step(input int l, input int o, input int p);
    @(negedge clk_i);
    line_i = 10'(l); field_odd_i = o[0]; pixel_i = 10'(p);
    @(posedge clk_i); #1;
  endtask

  task automatic idle();
    step(19, 0, 50);
  endtask

  task automatic chk(input string req, input logic [2:0] exp);
    logic [2:0] act;
    act = {scanline1_o, scanline2_o, hpos_o};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {s1,s2,h} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic wr(input bit is_v, input logic [31:0] d);
    @(negedge clk_i);
    line_i = 10'd19; field_odd_i = 1'b0; pixel_i = 10'd50;
    vcmp_we_i = is_v; hcmp_we_i = !is_v; wdata_i = d;
    @(posedge clk_i); #1;
    vcmp_we_i = 1'b0; hcmp_we_i = 1'b0;
  endtask

  function automatic logic [31:0] hword(int ln, int md, int ps);
    return (32'(ps) << 16) | (32'(md) << 12) | 32'(ln);
  endfunction

  initial begin
    #100_000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 chk("R10 reset", 3'b000);
    @(negedge clk_i) rst_ni = 1'b1;
    idle(); chk("R10 idle after reset", 3'b000);
    step(0, 0, 0); chk("R10 reset targets zero", 3'b111);

    wr(1'b1, 32'h0003_0007);
    wr(1'b0, hword(5, 0, 20));
    for (int i = 0; i < NV; i++) begin
      idle();
      step(VL[i], VO[i], VP[i]);
      chk($sformatf("R2 R4 vector %0d", i), 3'(VE[i]));
    end

    // R9: held match gives a single pulse
    idle(); step(6, 0, 0); chk("R9 first", 3'b100);
    step(6, 0, 0); chk("R9 held", 3'b000);
    step(6, 0, 0); chk("R9 held again", 3'b000);

    // R1: bits outside the two fields ignored; R10 write effect next clock
    wr(1'b1, 32'hFC00_FC03);
    idle(); step(6, 0, 0); chk("R1 s2 from low field, R10", 3'b010);
    idle(); step(0, 0, 0); chk("R1 s1 upper garbage dropped", 3'b100);

    // R3: mapped line beyond total never fires
    wr(1'b1, 32'h000A_0009);
    idle(); step(20, 0, 0); chk("R3 s1 line 20 out of range", 3'b000);
    idle(); step(19, 1, 0); chk("R3 s2 line 19 in range", 3'b010);

    // R5: mode 3 like mode 0
    wr(1'b0, hword(4, 3, 10));
    idle(); step(9, 1, 10); chk("R5 mode3 odd", 3'b001);
    idle(); step(8, 0, 10); chk("R5 mode3 even", 3'b001);
    idle(); step(8, 0, 10); chk("R5 mode3 repeat per frame", 3'b001);

    // R8: position clamped to last pixel
    wr(1'b0, hword(2, 0, 500));
    idle(); step(4, 0, 99); chk("R8 clamp", 3'b001);

    // R6: mode 1, N=4 from line 8 -> targets 8, 12->2, 6, 10
    @(negedge clk_i); line_i = 10'd8;
    hcmp_we_i = 1'b1; wdata_i = hword(4, 1, 30);
    @(posedge clk_i); #1 hcmp_we_i = 1'b0;
    idle(); step(12, 0, 30); chk("R6 initial target not line 12", 3'b000);
    idle(); step(16, 0, 30); chk("R6 initial target 8", 3'b001);
    idle(); step(4, 0, 30); chk("R6 wrapped target 2", 3'b001);
    idle(); step(12, 0, 30); chk("R6 target 6", 3'b001);

    // R6: initial wrap, N larger than half frame
    @(negedge clk_i); line_i = 10'd0;
    hcmp_we_i = 1'b1; wdata_i = hword(25, 1, 30);
    @(posedge clk_i); #1 hcmp_we_i = 1'b0;
    idle(); step(10, 0, 30); chk("R6 multi wrap target 5", 3'b001);

    // R7: mode 2, step of 1 from line 8
    @(negedge clk_i); line_i = 10'd8;
    hcmp_we_i = 1'b1; wdata_i = hword(9, 2, 30);
    @(posedge clk_i); #1 hcmp_we_i = 1'b0;
    idle(); step(10, 0, 30); chk("R7 first line", 3'b001);
    idle(); step(12, 0, 30); chk("R7 next line", 3'b001);
    idle(); step(10, 0, 30); chk("R7 old line no fire", 3'b000);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule